// File: doc/BRIEF.md
# Indirect-Configured Parallel I/O Port Controller

This block drives twenty general-purpose lines, grouped as two 8-bit ports (A, B) and one 4-bit port (C), from a host window of four 16-bit words. Three words give direct access to each port's output latch and line readback. The fourth word is a control word. Every configuration register sits behind it: per-line direction, per-line open-drain select, a master enable per port, and a software reset bit. Each configuration write takes two host writes. The first loads an internal register address and the second loads the value.

Software first issues a reset sequence on the control word. It then selects open-drain or push-pull per line and picks outputs. Next it writes the port latches and finally switches the ports on through the master configuration register. Each pin is presented as a separate output-enable, output-value and input-sample signal, so any pad style can be wrapped around it.

Top module: `pio_ctrl`

## Requirements
- R1: After hardware reset every line is an input, no line is open-drain, all port enables are off, all latches hold 0, no pin is driven, and the control word expects an address.
- R2: Host word index 0 is port C, 1 is port B, 2 is port A and 3 is the control word. Data uses bits 7:0 and read bits 15:8 are always 0. Read data appears on the cycle after the read strobe and holds until the next read.
- R3: In address phase a control write stores bits 7:0 as the internal address and moves to data phase. A data-phase write updates the addressed register and returns to address phase.
- R4: Internal addresses: direction A/B/C at 0x23/0x2B/0x06, open-drain select A/B/C at 0x24/0x2C/0x07, master configuration at 0x01, master interrupt control at 0x00 (bit 0 is software reset).
- R5: Master configuration bit 2 enables port A, bit 7 enables port B and bit 4 enables port C. A disabled port drives none of its pins.
- R6: On an enabled port, a direction bit of 0 makes the line an output and a 1 makes it an input that is never driven. A push-pull output drives its latch value with output-enable 1.
- R7: An output whose open-drain bit is 1 never drives high. Its output-enable is the inverse of its latch bit and its output value is 0.
- R8: A port read returns the two-stage-synchronised pin level on input lines and the latch value on output lines. Port C uses only bits 3:0.
- R9: A data-phase write of 1 in bit 0 at address 0x00 asserts software reset and restores the R1 state. While it is asserted, port writes and control writes with bit 0 set are ignored. A control write with bit 0 clear releases it, so 0x0000, 0x0001, 0x0000 from address phase resets the block.
- R10: A control-word read returns the register at the current internal address (0x00 reads the reset bit) and returns the sequencer to address phase.
- R11: A data write to an unimplemented address changes nothing but still completes the data phase. Such addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_word | input | 2 | Host word index |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, registered |
| pin_in | input | 20 | Pin levels, asynchronous |
| pin_oe | output | 20 | Per-line output enable |
| pin_out | output | 20 | Per-line output value |

## Verification
Two events can land on the same clock edge. One is a data-phase write that turns a line from output to input. The other is a new pin level entering the synchroniser on that line. The bench changes the pin level in the same cycle it issues the direction write. It then checks that output-enable drops right after that edge. Once the synchroniser has settled, the port read must show the new pin level on the flipped lines and the latch value on the lines that stayed outputs.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BUS_W = 16;
    localparam int REG_W = 8;

    localparam logic [7:0] IA_INT    = 8'h00;
    localparam logic [7:0] IA_CONF   = 8'h01;
    localparam logic [7:0] IA_DIR_A  = 8'h23;
    localparam logic [7:0] IA_DIR_B  = 8'h2B;
    localparam logic [7:0] IA_DIR_C  = 8'h06;
    localparam logic [7:0] IA_OD_A   = 8'h24;
    localparam logic [7:0] IA_OD_B   = 8'h2C;
    localparam logic [7:0] IA_OD_C   = 8'h07;

    localparam int EN_BIT_A = 2;
    localparam int EN_BIT_B = 7;
    localparam int EN_BIT_C = 4;

    localparam logic [1:0] WIN_C   = 2'd0;
    localparam logic [1:0] WIN_B   = 2'd1;
    localparam logic [1:0] WIN_A   = 2'd2;
    localparam logic [1:0] WIN_CTL = 2'd3;

    typedef enum logic {PH_PTR = 1'b0, PH_DATA = 1'b1} phase_e;

    typedef struct packed {
        phase_e                    phase;
        logic [REG_W-1:0]          ptr;
        logic                      soft_rst;
        logic [2:0][REG_W-1:0]     dir;
        logic [2:0][REG_W-1:0]     od;
        logic [REG_W-1:0]          conf;
    } cfg_state_t;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/pio_cfg_seq.sv
module pio_cfg_seq
    import pio_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int C_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic                   ctl_rd,
    input  logic [REG_W-1:0]       ctl_wdata,
    output logic [2:0][REG_W-1:0]  dir_o,
    output logic [2:0][REG_W-1:0]  od_o,
    output logic [REG_W-1:0]       conf_o,
    output logic                   soft_rst_o,
    output phase_e                 phase_o,
    output logic [REG_W-1:0]       rd_val_o
);
    localparam logic [REG_W-1:0] MASK_A = REG_W'((1 << A_W) - 1);
    localparam logic [REG_W-1:0] MASK_B = REG_W'((1 << B_W) - 1);
    localparam logic [REG_W-1:0] MASK_C = REG_W'((1 << C_W) - 1);
    localparam logic [2:0][REG_W-1:0] MASKS = {MASK_C, MASK_B, MASK_A};
    localparam cfg_state_t CFG_RST = '{
        phase:    PH_PTR,
        ptr:      '0,
        soft_rst: 1'b0,
        dir:      MASKS,
        od:       '0,
        conf:     '0
    };

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.soft_rst) begin
            if (ctl_wr && !ctl_wdata[0]) begin
                s_d.soft_rst = 1'b0;
            end else if (ctl_rd) begin
                s_d.phase = PH_PTR;
            end
        end else if (ctl_wr) begin
            if (s_q.phase == PH_PTR) begin
                s_d.ptr   = ctl_wdata;
                s_d.phase = PH_DATA;
            end else begin
                s_d.phase = PH_PTR;
                case (s_q.ptr)
                    IA_INT: begin
                        if (ctl_wdata[0]) begin
                            s_d          = CFG_RST;
                            s_d.soft_rst = 1'b1;
                        end
                    end
                    IA_CONF:  s_d.conf   = ctl_wdata;
                    IA_DIR_A: s_d.dir[0] = ctl_wdata & MASKS[0];
                    IA_DIR_B: s_d.dir[1] = ctl_wdata & MASKS[1];
                    IA_DIR_C: s_d.dir[2] = ctl_wdata & MASKS[2];
                    IA_OD_A:  s_d.od[0]  = ctl_wdata & MASKS[0];
                    IA_OD_B:  s_d.od[1]  = ctl_wdata & MASKS[1];
                    IA_OD_C:  s_d.od[2]  = ctl_wdata & MASKS[2];
                    default:  ;
                endcase
            end
        end else if (ctl_rd) begin
            s_d.phase = PH_PTR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CFG_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        case (s_q.ptr)
            IA_INT:   rd_val_o = {{(REG_W-1){1'b0}}, s_q.soft_rst};
            IA_CONF:  rd_val_o = s_q.conf;
            IA_DIR_A: rd_val_o = s_q.dir[0];
            IA_DIR_B: rd_val_o = s_q.dir[1];
            IA_DIR_C: rd_val_o = s_q.dir[2];
            IA_OD_A:  rd_val_o = s_q.od[0];
            IA_OD_B:  rd_val_o = s_q.od[1];
            IA_OD_C:  rd_val_o = s_q.od[2];
            default:  rd_val_o = '0;
        endcase
    end

    assign dir_o      = s_q.dir;
    assign od_o       = s_q.od;
    assign conf_o     = s_q.conf;
    assign soft_rst_o = s_q.soft_rst;
    assign phase_o    = s_q.phase;
endmodule

// File: rtl/pio_port.sv
module pio_port #(
    parameter int W     = 8,
    parameter int RD_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  logic [W-1:0]    wdata,
    input  logic [W-1:0]    dir,
    input  logic [W-1:0]    od,
    input  logic            en,
    input  logic [W-1:0]    pin_s,
    output logic [W-1:0]    oe,
    output logic [W-1:0]    out,
    output logic [RD_W-1:0] rd_val
);
    logic [W-1:0] latch_d, latch_q;
    logic [W-1:0] drv;

    always_comb begin
        latch_d = latch_q;
        if (clr)     latch_d = '0;
        else if (wr) latch_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    always_comb begin
        drv = en ? ~dir : '0;
        oe  = drv & ~(od & latch_q);
        out = drv & ~od & latch_q;
        rd_val = '0;
        rd_val[W-1:0] = (dir & pin_s) | (~dir & latch_q);
    end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int C_W = 4,
    localparam int NPIN = A_W + B_W + C_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_word,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]  pin_in,
    output logic [NPIN-1:0]  pin_oe,
    output logic [NPIN-1:0]  pin_out
);
    logic                  ctl_wr, ctl_rd, soft_rst;
    phase_e                phase;
    logic [2:0][REG_W-1:0] dir_cfg, od_cfg, port_rv;
    logic [REG_W-1:0]      conf, cfg_rv;
    logic [NPIN-1:0]       pin_s, dir_all, od_all, en_lines;
    logic [2:0]            port_en;
    logic [BUS_W-1:0]      rdata_d, rdata_q;
    logic                  unused_hi;

    assign unused_hi = ^{bus_wdata[BUS_W-1:REG_W], conf};

    assign ctl_wr = bus_wr && (bus_word == WIN_CTL);
    assign ctl_rd = bus_rd && !bus_wr && (bus_word == WIN_CTL);

    pio_cfg_seq #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_rd    (ctl_rd),
        .ctl_wdata (bus_wdata[REG_W-1:0]),
        .dir_o     (dir_cfg),
        .od_o      (od_cfg),
        .conf_o    (conf),
        .soft_rst_o(soft_rst),
        .phase_o   (phase),
        .rd_val_o  (cfg_rv)
    );

    pio_sync #(.W(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (pin_s)
    );

    for (genvar g = 0; g < 3; g++) begin : g_port
        localparam int         W      = (g == 0) ? A_W : (g == 1) ? B_W : C_W;
        localparam int         LO     = (g == 0) ? 0 : (g == 1) ? A_W : A_W + B_W;
        localparam logic [1:0] WIN    = (g == 0) ? WIN_A : (g == 1) ? WIN_B : WIN_C;
        localparam int         EN_BIT = (g == 0) ? EN_BIT_A : (g == 1) ? EN_BIT_B : EN_BIT_C;

        logic wr;
        assign wr = bus_wr && (bus_word == WIN);
        assign port_en[g]       = conf[EN_BIT];
        assign dir_all[LO +: W] = dir_cfg[g][W-1:0];
        assign od_all[LO +: W]  = od_cfg[g][W-1:0];
        assign en_lines[LO +: W] = {W{port_en[g]}};

        if (W < REG_W) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^{dir_cfg[g][REG_W-1:W], od_cfg[g][REG_W-1:W]};
        end

        pio_port #(.W(W), .RD_W(REG_W)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (soft_rst),
            .wr    (wr),
            .wdata (bus_wdata[W-1:0]),
            .dir   (dir_cfg[g][W-1:0]),
            .od    (od_cfg[g][W-1:0]),
            .en    (port_en[g]),
            .pin_s (pin_s[LO +: W]),
            .oe    (pin_oe[LO +: W]),
            .out   (pin_out[LO +: W]),
            .rd_val(port_rv[g])
        );
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd && !bus_wr) begin
            case (bus_word)
                WIN_CTL: rdata_d = {{(BUS_W-REG_W){1'b0}}, cfg_rv};
                WIN_A:   rdata_d = {{(BUS_W-REG_W){1'b0}}, port_rv[0]};
                WIN_B:   rdata_d = {{(BUS_W-REG_W){1'b0}}, port_rv[1]};
                default: rdata_d = {{(BUS_W-REG_W){1'b0}}, port_rv[2]};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
    import pio_pkg::*;
#(
    parameter int NPIN = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_word,
    input logic [BUS_W-1:0] bus_rdata,
    input logic [NPIN-1:0]  pin_oe,
    input logic [NPIN-1:0]  pin_out,
    input logic             soft_rst,
    input phase_e           phase,
    input logic [NPIN-1:0]  dir_all,
    input logic [NPIN-1:0]  od_all,
    input logic [NPIN-1:0]  en_lines
);
    assert_rdata_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:REG_W] == '0);

    assert_ptr_to_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == WIN_CTL && phase == PH_PTR && !soft_rst) |=> (phase == PH_DATA));

    assert_disabled_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~en_lines) == '0);

    assert_inputs_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_all) == '0);

    assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & od_all) == '0);

    assert_softrst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (pin_oe == '0));

    assert_ctl_read_rewinds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_word == WIN_CTL) |=> (phase == PH_PTR));
endmodule

bind pio_ctrl pio_ctrl_chk #(.NPIN(NPIN)) u_chk (.*);

// File: tb/pio_ctrl_test.sv
`timescale 1ns/1ps
module pio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_word;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [19:0] pin_in, pin_oe, pin_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    localparam logic [1:0] W_C = 2'd0, W_B = 2'd1, W_A = 2'd2, W_CTL = 2'd3;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_word = w;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cfg(input logic [7:0] a, input logic [7:0] v);
        wr(W_CTL, {8'h00, a});
        wr(W_CTL, {8'h00, v});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 oe after reset", pin_oe, 20'h0);
        rd(W_A, d); check("R1/R8 port A reads pins", d, 16'h00C3);
        rd(W_B, d); check("R2 port B word", d, 16'h005A);
        rd(W_C, d); check("R2 port C word", d, 16'h0009);
        rd(W_CTL, d); check("R1 ctl reads reset reg", d, 16'h0000);
    endtask

    task automatic t_push_pull();
        logic [15:0] d;
        cfg(8'h23, 8'h00);
        cfg(8'h01, 8'h04);
        wr(W_A, 16'h005A);
        check("R6 A oe", pin_oe[7:0], 8'hFF);
        check("R6 A out", pin_out[7:0], 8'h5A);
        check("R5 B,C undriven", pin_oe[19:8], 12'h0);
        rd(W_A, d); check("R8 A output readback", d, 16'h005A);
    endtask

    task automatic t_enables();
        cfg(8'h2B, 8'h0F);
        cfg(8'h01, 8'h00);
        check("R5 all disabled", pin_oe, 20'h0);
        cfg(8'h01, 8'h94);
        check("R4/R6 B dir split", pin_oe[15:8], 8'hF0);
        check("R5 A enabled", pin_oe[7:0], 8'hFF);
        check("R6 C inputs undriven", pin_oe[19:16], 4'h0);
    endtask

    task automatic t_open_drain();
        logic [15:0] d;
        cfg(8'h24, 8'hFF);
        check("R7 A od oe", pin_oe[7:0], 8'hA5);
        check("R7 A od out", pin_out[7:0], 8'h00);
        cfg(8'h06, 8'h00);
        cfg(8'h07, 8'h0F);
        wr(W_C, 16'h00F3);
        check("R7 C od oe", pin_oe[19:16], 4'hC);
        check("R7 C od out", pin_out[19:16], 4'h0);
        rd(W_C, d); check("R8 C latch low nibble", d, 16'h0003);
    endtask

    task automatic t_input_mix();
        logic [15:0] d;
        @(negedge clk); pin_in[15:8] = 8'hA6;
        wr(W_B, 16'h0035);
        repeat (3) @(negedge clk);
        rd(W_B, d); check("R8 B mixed readback", d, 16'h0036);
        check("R6 B push-pull out", pin_out[15:8], 8'h30);
    endtask

    task automatic t_ctl_read();
        logic [15:0] d;
        wr(W_CTL, 16'h002B);
        rd(W_CTL, d); check("R10 ctl read pointed reg", d, 16'h000F);
        wr(W_CTL, 16'h0024);
        rd(W_CTL, d); check("R10 write after read is address", d, 16'h00FF);
        check("R3 A od unchanged", pin_oe[7:0], 8'hA5);
    endtask

    task automatic t_unimpl();
        logic [15:0] d;
        logic [19:0] oe_before;
        oe_before = pin_oe;
        cfg(8'h55, 8'h12);
        check("R11 unimpl write no effect", pin_oe, oe_before);
        wr(W_CTL, 16'h0024);
        wr(W_CTL, 16'h0000);
        check("R11 phase consumed, A push-pull", pin_oe[7:0], 8'hFF);
        check("R3 A out latch", pin_out[7:0], 8'h5A);
        wr(W_CTL, 16'h0055);
        rd(W_CTL, d); check("R11 unimpl reads 0", d, 16'h0000);
    endtask

    task automatic t_concurrent();
        logic [15:0] d;
        wr(W_CTL, 16'h0023);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = W_CTL; bus_wdata = 16'h00F0;
        pin_in[7:0] = 8'h3C;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R6 oe drops with dir write", pin_oe[7:0], 8'h0F);
        repeat (2) @(negedge clk);
        rd(W_A, d); check("R8 new pin on flipped lines", d, 16'h003A);
    endtask

    task automatic t_soft_reset();
        logic [15:0] d;
        wr(W_CTL, 16'h0000);
        wr(W_CTL, 16'h0001);
        check("R9 reset quiets pins", pin_oe, 20'h0);
        wr(W_A, 16'h00FF);
        wr(W_CTL, 16'h0003);
        rd(W_CTL, d); check("R9 still in reset", d, 16'h0001);
        wr(W_CTL, 16'h0000);
        rd(W_CTL, d); check("R9 released", d, 16'h0000);
        rd(W_A, d); check("R9 A back to input", d, 16'h003C);
        rd(W_B, d); check("R9 B back to input", d, 16'h00A6);
        cfg(8'h23, 8'h00);
        cfg(8'h01, 8'h04);
        check("R9 A oe after re-enable", pin_oe[7:0], 8'hFF);
        check("R9 latch cleared, write ignored", pin_out[7:0], 8'h00);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_word = 2'd0; bus_wdata = 16'h0;
        pin_in = 20'h95AC3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_push_pull();
        t_enables();
        t_open_drain();
        t_input_mix();
        t_ctl_read();
        t_unimpl();
        t_concurrent();
        t_soft_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule